// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the feedback divider of a phase-locked loop. It counts cycles of the oscillator clock. Once per full division cycle it emits a single-clock comparison pulse, `fpd_pulse`, for the phase comparator. The division uses the pulse-swallow scheme. A modulus stage divides by either 2^N or 2^N+1, which is 16 or 17 by default. A sub-cycle counter of `M_W` bits and a swallow counter of `A_W` bits choose the modulus for each sub-cycle. The total ratio is therefore 16·M + A.

An optional divide-by-two front stage is turned on by the static input `pre_en`. When it is on, every count advances only on every second oscillator clock, so the ratio doubles. The ratio inputs `ratio_m` and `ratio_a` are held outside the block. They are sampled only in the clock in which the comparison pulse is high, so a ratio change never cuts a division cycle short.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst_n` is low, `fpd_pulse` is low. The first division cycle after reset release uses the ratio 16, whatever the ratio inputs hold. With `pre_en`=0 its pulse is high in the 16th clock cycle after release.
- R2: With `pre_en`=0, consecutive rising edges of `fpd_pulse` are 16·M + A clocks apart, where M=`ratio_m` and A=`ratio_a`.
- R3: With `pre_en`=1, consecutive pulses are 2·(16·M + A) clocks apart.
- R4: `fpd_pulse` is high for exactly one clock per division cycle, in both prescaler settings.
- R5: Changes on `ratio_m`/`ratio_a` between pulses have no effect on the running cycle. The values present in the clock where `fpd_pulse` is high set the length of the next cycle.
- R6: A pair with M=0, or with A>M, is replaced by the minimum ratio 16, which becomes 32 with `pre_en`=1.
- R7: A=M is valid, with every sub-cycle at 17. A=0 is valid, with every sub-cycle at 16. Both follow the R2 formula.
- R8: M values wider than 8 bits divide correctly. For example, M=300 and A=7 give 4807.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_en | input | 1 | Static front divide-by-two enable |
| ratio_m | input | M_W (13) | Sub-cycle count M from the holding register |
| ratio_a | input | A_W (4) | Swallow count A from the holding register |
| fpd_pulse | output | 1 | One-clock comparison pulse at each cycle end |

## Verification
The hardest situation to reach from the ports is a ratio change that arrives partway through a division cycle. The stimulus first loads one ratio at a pulse. Ten clocks later, in the middle of that cycle, it changes the inputs. It then measures one interval that must still match the old ratio and one that must match the new one. The rest of the stimulus is near-exhaustive. Every valid (M, A) pair with M up to 12 is swept without the prescaler, and every A is swept at M=15 with the prescaler on. Invalid pairs, the swallow extremes and one wide M are each timed against the arithmetic ratio.

// File: rtl/psd_pkg.sv
package psd_pkg;
   // modulus request from the swallow counter to the modulus stage
   typedef enum logic {
      MOD_LO = 1'b0,   // divide by 2^N
      MOD_HI = 1'b1    // divide by 2^N + 1
   } mod_sel_e;
endpackage

// File: rtl/psd_prescale.sv
module psd_prescale #(
   parameter bit HAS_PRE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pre_en,
   output logic tick
);
   generate
      if (HAS_PRE) begin : g_pre
         logic phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) phase_q <= 1'b0;
            else        phase_q <= ~phase_q;
         end
         assign tick = pre_en ? phase_q : 1'b1;
      end else begin : g_nopre
         logic unused_pre;
         assign unused_pre = pre_en;
         assign tick       = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/psd_modulus.sv
module psd_modulus
   import psd_pkg::*;
#(
   parameter int N_LOG = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  mod_sel_e          mod_sel,
   output logic              sub_end,
   output logic [N_LOG:0]    phase_cnt
);
   localparam int          PC_W   = N_LOG + 1;
   localparam logic [PC_W-1:0] LAST_LO = PC_W'((1 << N_LOG) - 1);
   localparam logic [PC_W-1:0] LAST_HI = PC_W'(1 << N_LOG);

   logic [PC_W-1:0] last_val;

   assign last_val = (mod_sel == MOD_HI) ? LAST_HI : LAST_LO;
   assign sub_end  = tick && (phase_cnt == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_cnt <= '0;
      else if (sub_end) phase_cnt <= '0;
      else if (tick)    phase_cnt <= phase_cnt + 1'b1;
   end
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow
   import psd_pkg::*;
#(
   parameter int M_W = 13,
   parameter int A_W = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sub_end,
   input  logic [M_W-1:0] m_in,
   input  logic [A_W-1:0] a_in,
   output mod_sel_e       mod_sel,
   output logic           cyc_end,
   output logic [M_W-1:0] cur_m,
   output logic [A_W-1:0] cur_a
);
   localparam logic [M_W-1:0] M_ONE = M_W'(1);

   logic [M_W-1:0] m_left;
   logic [A_W-1:0] a_left;
   logic [M_W-1:0] a_wide;
   logic           pair_ok;
   logic [M_W-1:0] ld_m;
   logic [A_W-1:0] ld_a;

   assign a_wide  = M_W'(a_in);
   assign pair_ok = (m_in != '0) && (a_wide <= m_in);
   assign ld_m    = pair_ok ? m_in : M_ONE;
   assign ld_a    = pair_ok ? a_in : '0;

   assign cyc_end = sub_end && (m_left == M_ONE);
   assign mod_sel = (a_left != '0) ? MOD_HI : MOD_LO;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_left <= M_ONE;
         a_left <= '0;
         cur_m  <= M_ONE;
         cur_a  <= '0;
      end else if (cyc_end) begin
         m_left <= ld_m;
         a_left <= ld_a;
         cur_m  <= ld_m;
         cur_a  <= ld_a;
      end else if (sub_end) begin
         m_left <= m_left - 1'b1;
         if (a_left != '0) a_left <= a_left - 1'b1;
      end
   end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
   import psd_pkg::*;
#(
   parameter int M_W     = 13,
   parameter int A_W     = 4,
   parameter int N_LOG   = 4,
   parameter bit HAS_PRE = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pre_en,
   input  logic [M_W-1:0] ratio_m,
   input  logic [A_W-1:0] ratio_a,
   output logic           fpd_pulse
);
   generate
      if (A_W > N_LOG) begin : g_bad_a
         $error("swallow count must stay below the modulus");
      end
      if (M_W < A_W) begin : g_bad_m
         $error("sub-cycle counter narrower than swallow counter");
      end
   endgenerate

   logic           tick;
   logic           sub_end;
   logic           cyc_end;
   mod_sel_e       mod_sel;
   logic [N_LOG:0] phase_cnt;
   logic [M_W-1:0] cur_m;
   logic [A_W-1:0] cur_a;

   psd_prescale #(.HAS_PRE(HAS_PRE)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .pre_en (pre_en),
      .tick   (tick)
   );

   psd_modulus #(.N_LOG(N_LOG)) u_mod (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .mod_sel   (mod_sel),
      .sub_end   (sub_end),
      .phase_cnt (phase_cnt)
   );

   psd_swallow #(.M_W(M_W), .A_W(A_W)) u_swl (
      .clk     (clk),
      .rst_n   (rst_n),
      .sub_end (sub_end),
      .m_in    (ratio_m),
      .a_in    (ratio_a),
      .mod_sel (mod_sel),
      .cyc_end (cyc_end),
      .cur_m   (cur_m),
      .cur_a   (cur_a)
   );

   assign fpd_pulse = cyc_end;
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
   parameter int M_W     = 13,
   parameter int A_W     = 4,
   parameter int N_LOG   = 4,
   parameter bit HAS_PRE = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           pre_en,
   input logic           fpd_pulse,
   input logic           tick,
   input logic [N_LOG:0] phase_cnt,
   input logic [M_W-1:0] cur_m,
   input logic [A_W-1:0] cur_a
);
   localparam logic [N_LOG:0] PC_MAX = (N_LOG+1)'(1 << N_LOG);

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fpd_pulse |=> !fpd_pulse);

   a_r4_pulse_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      fpd_pulse |-> tick);

   a_r3_tick_alternates: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_PRE && pre_en && tick) |=> !tick);

   a_r5_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
      !fpd_pulse |=> ($stable(cur_m) && $stable(cur_a)));

   a_r6_ratio_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_m != '0) && (M_W'(cur_a) <= cur_m));

   a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
      phase_cnt <= PC_MAX);
endmodule

bind pulse_swallow_div psd_checker #(
   .M_W(M_W), .A_W(A_W), .N_LOG(N_LOG), .HAS_PRE(HAS_PRE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pre_en    (pre_en),
   .fpd_pulse (fpd_pulse),
   .tick      (tick),
   .phase_cnt (phase_cnt),
   .cur_m     (cur_m),
   .cur_a     (cur_a)
);

// File: tb/pulse_swallow_div_bench.sv
module pulse_swallow_div_bench;
   localparam int CLK_PERIOD = 10;
   localparam int M_W = 13;
   localparam int A_W = 4;
   localparam int WATCHDOG = 190000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           pre_en = 1'b0;
   logic [M_W-1:0] ratio_m = '0;
   logic [A_W-1:0] ratio_a = '0;
   logic           fpd_pulse;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pulse_swallow_div u_pulse_swallow_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .pre_en    (pre_en),
      .ratio_m   (ratio_m),
      .ratio_a   (ratio_a),
      .fpd_pulse (fpd_pulse)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         failures++;
         $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   function automatic int exp_ratio(input int m, input int a, input bit de);
      int base;
      base = (m != 0 && a <= m) ? 16*m + a : 16;
      return de ? 2*base : base;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_pulse();
      while (!fpd_pulse) @(negedge clk);
   endtask

   task automatic do_reset(input bit de);
      @(negedge clk);
      rst_n   = 1'b0;
      pre_en  = de;
      ratio_m = 13'd5;
      ratio_a = 4'd3;
      repeat (3) @(negedge clk);
      check("R1 pulse low in reset", int'(fpd_pulse), 0);
      rst_n = 1'b1;
   endtask

   // load (m,a) at a pulse, then time the interval to the next pulse
   task automatic run(input int m, input int a, input string tag);
      int cnt;
      wait_pulse();
      ratio_m = M_W'(m);
      ratio_a = A_W'(a);
      @(negedge clk);
      cnt = 1;
      check({"R4 width ", tag}, int'(fpd_pulse), 0);
      while (!fpd_pulse) begin
         @(negedge clk);
         cnt++;
      end
      check(tag, cnt, exp_ratio(m, a, pre_en));
   endtask

   initial begin
      int cnt;
      // R1: first cycle is 16 regardless of inputs (5,3 held during reset)
      do_reset(1'b0);
      cnt = 0;
      while (!fpd_pulse) begin
         @(negedge clk);
         cnt++;
      end
      check("R1 first pulse cycle", cnt, 15);

      // R2, R7: sweep all valid pairs with small M, no prescaler
      for (int m = 1; m <= 12; m++) begin
         for (int a = 0; a <= m && a <= 15; a++) begin
            if (a == m || a == 0) run(m, a, "R7 swallow extreme");
            else                  run(m, a, "R2 period");
         end
      end

      // R6: invalid pairs fall back to 16
      run(0, 0, "R6 m zero");
      run(0, 9, "R6 m zero a nonzero");
      run(3, 5, "R6 a above m");
      run(15, 15, "R7 a equals m at max a");

      // R8: wide M
      run(300, 7, "R8 wide m");

      // R5: change mid-cycle, old ratio finishes, new applies next
      run(2, 0, "R2 settle");
      wait_pulse();
      ratio_m = 13'd4;
      ratio_a = 4'd2;
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
         if (cnt == 10) begin
            ratio_m = 13'd2;
            ratio_a = 4'd1;
         end
      end while (!fpd_pulse);
      check("R5 mid-cycle change ignored", cnt, 66);
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (!fpd_pulse);
      check("R5 new ratio at boundary", cnt, 33);

      // R3: prescaler on
      do_reset(1'b1);
      for (int a = 0; a <= 15; a++) run(15, a, "R3 prescaled period");
      run(1, 0, "R3 prescaled minimum");
      run(0, 4, "R6 prescaled fallback");
      run(7, 9, "R6 prescaled a above m");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule